// File: doc/BRIEF.md
# Eight-bit ALU with Status Flag Register

This block is the arithmetic core of a small eight-bit processor. In one cycle it combines two 8-bit operands with one of eight arithmetic or logic operations. It drives the result as combinational logic. On the rising clock edge that ends the operation, it stores the flags that describe the result in an 8-bit status register.

The same opcode input also carries four flag operations. Two of them set or clear the global interrupt-enable bit. The other two move one selected operand bit into the T bit, or write the T bit into a selected bit of the operand. The next operation sees the stored flags. A chain of add-with-carry or subtract-with-carry operations therefore spans several bytes with no outside help. The caller keeps instruction fetch, decode and register storage.

Top module: `alu_flags`

## Requirements
- R1: Opcodes 0 to 7 select add, add with carry, subtract, subtract with carry, AND, OR, XOR and AND-with-immediate (the immediate arrives on `opb`). Each drives its 8-bit result on `res` combinationally within the same cycle.
- R2: `sreg` holds, from bit 7 down to bit 0, I, T, H, S, V, N, Z and C. It reads zero after reset.
- R3: For opcodes 0 to 3, H is set on a carry out of bit 3 (add) or a borrow into bit 3 (subtract).
- R4: For opcodes 0 to 7, N takes bit 7 of the result, and Z is set exactly when the result is zero.
- R5: For opcodes 0 to 3, C is set on a carry out of bit 7 or a borrow into bit 7. Opcodes 1 and 3 use the stored C as carry-in or borrow-in, so each operation sees the C left by the operation before it.
- R6: V is set for an add when both operands have the same sign and the result sign differs from it. V is set for a subtract when the operand signs differ and the result sign differs from the first operand.
- R7: After any opcode from 0 to 7, S equals N XOR V.
- R8: Logic opcodes 4 to 7 clear V and leave C and H unchanged.
- R9: Opcode 8 sets I and opcode 9 clears I. No other opcode changes I.
- R10: Opcode 10 loads T from `opa[bsel]`. Opcode 11 drives `res` as `opa` with bit `bsel` replaced by T. Opcodes 8 to 11 change no status bit other than their target bit, and opcodes 8 to 10 drive `res = opa`.
- R11: Opcodes 12 to 15 drive `res = opa` and leave `sreg` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the status register updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 4 | Operation code |
| opa | input | 8 | First operand |
| opb | input | 8 | Second operand or immediate |
| bsel | input | 3 | Bit index for the T copy operations |
| res | output | 8 | Combinational result |
| sreg | output | 8 | Status register |

## Verification
The bench targets the operands where bit 3 and bit 7 carry or borrow independently, such as 0x0F+0x01 and 0x10-0x01. A design that takes H from the wrong bit would flag the wrong one of these. It runs chained add-with-carry and subtract-with-carry operations, which catch a design that ignores the stored C or latches it a cycle late. It applies signed boundary pairs (0x7F+0x01, 0x80-0x01, 0x80+0x80): a swapped overflow rule would set V on the wrong pair, and a sign bit built from N alone would fail whenever V is set. Logic operations applied after a carry or half-carry must leave C and H unchanged. A design that clears them would show zeros there.

// File: rtl/alu_flags.sv
module alu_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] op,
  input  logic [7:0] opa,
  input  logic [7:0] opb,
  input  logic [2:0] bsel,
  output logic [7:0] res,
  output logic [7:0] sreg
);
  localparam logic [3:0] OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBC = 4'd3;
  localparam logic [3:0] OP_AND = 4'd4, OP_OR = 4'd5, OP_XOR = 4'd6, OP_ANDI = 4'd7;
  localparam logic [3:0] OP_SEI = 4'd8, OP_CLI = 4'd9, OP_BST = 4'd10, OP_BLD = 4'd11;
  localparam int FI = 7, FT = 6, FH = 5, FS = 4, FV = 3, FN = 2, FZ = 1, FC = 0;

  logic [7:0] nxt;
  logic       cin;
  logic [8:0] sum, dif;
  logic       is_add, is_sub, is_log;

  assign is_add = (op == OP_ADD) || (op == OP_ADC);
  assign is_sub = (op == OP_SUB) || (op == OP_SBC);
  assign is_log = (op[3:2] == 2'b01);
  assign cin    = (op == OP_ADC || op == OP_SBC) ? sreg[FC] : 1'b0;
  assign sum    = {1'b0, opa} + {1'b0, opb} + {8'd0, cin};
  assign dif    = {1'b0, opa} - {1'b0, opb} - {8'd0, cin};

  always_comb begin
    res = opa;
    nxt = sreg;
    case (op)
      OP_ADD, OP_ADC: begin
        res     = sum[7:0];
        nxt[FC] = sum[8];
        nxt[FH] = (opa[3] & opb[3]) | (opb[3] & ~res[3]) | (~res[3] & opa[3]);
        nxt[FV] = (opa[7] & opb[7] & ~res[7]) | (~opa[7] & ~opb[7] & res[7]);
      end
      OP_SUB, OP_SBC: begin
        res     = dif[7:0];
        nxt[FC] = dif[8];
        nxt[FH] = (~opa[3] & opb[3]) | (opb[3] & res[3]) | (res[3] & ~opa[3]);
        nxt[FV] = (opa[7] & ~opb[7] & ~res[7]) | (~opa[7] & opb[7] & res[7]);
      end
      OP_AND, OP_ANDI: begin res = opa & opb; nxt[FV] = 1'b0; end
      OP_OR:           begin res = opa | opb; nxt[FV] = 1'b0; end
      OP_XOR:          begin res = opa ^ opb; nxt[FV] = 1'b0; end
      OP_SEI:          nxt[FI] = 1'b1;
      OP_CLI:          nxt[FI] = 1'b0;
      OP_BST:          nxt[FT] = opa[bsel];
      OP_BLD:          res[bsel] = sreg[FT];
      default: ;
    endcase
    if (is_add || is_sub || is_log) begin
      nxt[FN] = res[7];
      nxt[FZ] = (res == 8'd0);
      nxt[FS] = res[7] ^ nxt[FV];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sreg <= 8'd0;
    else        sreg <= nxt;

  a_r9_i_only_by_flag_ops: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_SEI && op != OP_CLI) |=> $stable(sreg[FI]));
  a_r8_logic_keeps_c_h: assert property (@(posedge clk) disable iff (!rst_n)
    is_log |=> (sreg[FV] == 1'b0) && $stable(sreg[FC]) && $stable(sreg[FH]));
  a_r4_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (is_add || is_sub || is_log) |=> (sreg[FZ] == ($past(res) == 8'd0)) && (sreg[FN] == $past(res[7])));
  a_r10_bst_loads_t: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_BST) |=> sreg[FT] == $past(opa[bsel]));
  a_r11_idle_ops_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op[3:2] == 2'b11) |=> $stable(sreg));
  a_r10_flag_ops_keep_arith: assert property (@(posedge clk) disable iff (!rst_n)
    (op[3:2] == 2'b10) |=> $stable(sreg[5:0]));
endmodule

// File: tb/alu_flags_test.sv
module alu_flags_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] op = 4'd15;
  logic [7:0] opa = 8'd0, opb = 8'd0;
  logic [2:0] bsel = 3'd0;
  logic [7:0] res, sreg;
  int nchk = 0, nfail = 0;
  logic [7:0] m_sreg = 8'd0;
  bit done = 1'b0;

  alu_flags uut (.clk(clk), .rst_n(rst_n), .op(op), .opa(opa), .opb(opb),
                 .bsel(bsel), .res(res), .sreg(sreg));

  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h", tag, op, opa, opb, act, exp);
    end
  endtask

  function automatic logic [15:0] model(input logic [3:0] o, input logic [7:0] a,
                                        input logic [7:0] b, input logic [2:0] k,
                                        input logic [7:0] s);
    int ua, ub, c, r, sa, sb, sr;
    logic [7:0] rr, ns;
    ns = s; rr = a;
    c = (o == 1 || o == 3) ? int'(s[0]) : 0;
    ua = int'(a); ub = int'(b);
    sa = int'($signed(a)); sb = int'($signed(b));
    if (o <= 1) begin
      r = ua + ub + c; rr = r[7:0];
      ns[0] = r > 255;
      ns[5] = (int'(a[3:0]) + int'(b[3:0]) + c) > 15;
      sr = sa + sb + c; ns[3] = (sr > 127) || (sr < -128);
    end else if (o <= 3) begin
      r = ua - ub - c; rr = r[7:0];
      ns[0] = r < 0;
      ns[5] = (int'(a[3:0]) - int'(b[3:0]) - c) < 0;
      sr = sa - sb - c; ns[3] = (sr > 127) || (sr < -128);
    end else if (o <= 7) begin
      rr = (o == 5) ? (a | b) : (o == 6) ? (a ^ b) : (a & b);
      ns[3] = 1'b0;
    end else if (o == 8) ns[7] = 1'b1;
    else if (o == 9) ns[7] = 1'b0;
    else if (o == 10) ns[6] = a[k];
    else if (o == 11) rr[k] = s[6];
    if (o <= 7) begin
      ns[2] = rr[7];
      ns[1] = (rr == 8'd0);
      ns[4] = ns[2] ^ ns[3];
    end
    return {rr, ns};
  endfunction

  task automatic apply(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                       input logic [2:0] k);
    logic [15:0] e;
    @(negedge clk);
    op = o; opa = a; opb = b; bsel = k;
    #1;
    e = model(o, a, b, k, m_sreg);
    if (o <= 7)       check("R1 result", res, e[15:8]);
    else if (o == 11) check("R10 bit-load result", res, e[15:8]);
    else if (o <= 10) check("R10 flag-op result", res, e[15:8]);
    else              check("R11 idle result", res, e[15:8]);
    @(posedge clk); #1;
    check("R5 C", {7'd0, sreg[0]}, {7'd0, e[0]});
    check("R4 Z/N", {6'd0, sreg[2:1]}, {6'd0, e[2:1]});
    check("R6 V", {7'd0, sreg[3]}, {7'd0, e[3]});
    check("R7 S", {7'd0, sreg[4]}, {7'd0, e[4]});
    check("R3 H", {7'd0, sreg[5]}, {7'd0, e[5]});
    check("R10 T", {7'd0, sreg[6]}, {7'd0, e[6]});
    check("R9 I", {7'd0, sreg[7]}, {7'd0, e[7]});
    if (o >= 4 && o <= 7) check("R8 logic keeps C,H", {6'd0, sreg[5], sreg[0]}, {6'd0, m_sreg[5], m_sreg[0]});
    if (o >= 12) check("R11 idle sreg", sreg, m_sreg);
    m_sreg = e[7:0];
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R2 reset sreg", sreg, 8'd0);
    rst_n = 1'b1;
    apply(4'd0, 8'h0F, 8'h01, 3'd0);
    apply(4'd2, 8'h10, 8'h01, 3'd0);
    apply(4'd0, 8'h7F, 8'h01, 3'd0);
    apply(4'd2, 8'h80, 8'h01, 3'd0);
    apply(4'd0, 8'h80, 8'h80, 3'd0);
    apply(4'd4, 8'hF0, 8'h0F, 3'd0);
    apply(4'd1, 8'hFF, 8'h00, 3'd0);
    apply(4'd1, 8'h00, 8'h00, 3'd0);
    apply(4'd2, 8'h00, 8'h01, 3'd0);
    apply(4'd3, 8'h00, 8'h00, 3'd0);
    apply(4'd3, 8'h05, 8'h05, 3'd0);
    apply(4'd8, 8'h00, 8'h00, 3'd0);
    apply(4'd0, 8'hFF, 8'hFF, 3'd0);
    apply(4'd10, 8'h20, 8'h00, 3'd5);
    apply(4'd11, 8'h00, 8'h00, 3'd3);
    apply(4'd9, 8'h00, 8'h00, 3'd0);
    apply(4'd13, 8'hA5, 8'h5A, 3'd1);
    apply(4'd6, 8'hAA, 8'hAA, 3'd0);
    apply(4'd7, 8'hC3, 8'h81, 3'd0);
    void'($urandom(32'd2024));
    for (int i = 0; i < 3000; i++)
      apply(4'($urandom % 16), 8'($urandom), 8'($urandom), 3'($urandom));
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule